// File: doc/BRIEF.md
# Exception Cause Priority Selector

This block sits in a processor's trap path. Each cycle it takes a 24-bit vector of pending exception flags, where bit *i* stands for cause code *i*, together with a valid strobe. It reports whether any exception is eligible, and it gives the 5-bit cause code and a one-hot marker of the single exception that wins.

The winner is chosen by a fixed architectural ranking, not by the numeric value of the cause code. Fetch-side faults and breakpoints outrank environment calls, and environment calls outrank data-side faults. A front-end mode input restricts selection to the causes that fetch and decode can raise. A parameter adds one output register stage with synchronous reset.

Top module: `exc_cause_sel`

## Requirements
- R1: When `valid_i` is high and at least one eligible flag is set, `any_o` is high. In that case, `onehot_o` has a bit set at position `cause_o`.
- R2: The reported cause is the highest-ranked set eligible flag. The ranking from highest to lowest is the cause codes 3, 12, 20, 1, 2, 22, 0, 11, 9, 10, 8, 6, 4, 15, 13, 23, 21, 7, 5.
- R3: When no eligible flag is set, `any_o` is 0, `cause_o` is 0 and `onehot_o` is 0.
- R4: When `fe_only_i` is 1, only flags 0, 1, 2, 12, 20 and 22 are eligible. All other flags are treated as clear.
- R5: Flags 14, 16, 17, 18 and 19 are never selected, whatever the other inputs are.
- R6: `onehot_o` has at most one bit set.
- R7: With `REG_OUT`=1, the outputs reflect the inputs sampled at the previous rising clock edge. A high `rst` at a clock edge clears all outputs to 0.
- R8: When `valid_i` is 0, the flags are ignored and the outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Qualifies the flag vector |
| fe_only_i | input | 1 | 1 = only front-end causes are eligible |
| pend_i | input | 24 | Pending exception flags, bit i = cause code i |
| any_o | output | 1 | An eligible exception was found |
| cause_o | output | 5 | Cause code of the winner, 0 if none |
| onehot_o | output | 24 | One-hot marker of the winning flag |

## Verification
The properties assume the default one-cycle output latency. They also assume `rst` is held high from time zero through the first edge, so there is always a defined previous cycle. They place no constraint on the flag pattern: any 24-bit value, including the never-selected bits, is legal. The stimulus holds reset at the start and changes inputs only at falling edges. It mixes sparse and dense random patterns, both modes and occasional low strobes, with directed pairs that pit adjacent ranks against each other.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;
  localparam int VEC_W    = 24;
  localparam int CODE_W   = 5;
  localparam int NUM_PRIO = 19;

  // Rank 0 is highest; entries are cause codes.
  localparam logic [CODE_W-1:0] PRIO_ORDER [NUM_PRIO] = '{
    5'd3, 5'd12, 5'd20, 5'd1, 5'd2, 5'd22, 5'd0,
    5'd11, 5'd9, 5'd10, 5'd8,
    5'd6, 5'd4, 5'd15, 5'd13, 5'd23, 5'd21, 5'd7, 5'd5
  };

  // Causes eligible in front-end mode: 0,1,2,12,20,22
  localparam logic [VEC_W-1:0] FE_MASK = 24'h50_1007;
endpackage

// File: rtl/exc_src_mask.sv
module exc_src_mask
  import exc_sel_pkg::*;
#(
  parameter int W = VEC_W
) (
  input  logic         valid,
  input  logic         fe_only,
  input  logic [W-1:0] pend,
  output logic [W-1:0] elig
);
  localparam logic [W-1:0] FE_M = FE_MASK[W-1:0];

  always_comb begin
    if (!valid)       elig = '0;
    else if (fe_only) elig = pend & FE_M;
    else              elig = pend;
  end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
  import exc_sel_pkg::*;
#(
  parameter int W = VEC_W,
  parameter int N = NUM_PRIO
) (
  input  logic [W-1:0] elig,
  output logic [W-1:0] onehot
);
  // Pull flags into rank order so the scan runs over ranks.
  logic [N-1:0] ranked;
  for (genvar k = 0; k < N; k++) begin : g_rank
    assign ranked[k] = elig[PRIO_ORDER[k]];
  end

  logic found;
  always_comb begin
    onehot = '0;
    found  = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && ranked[k]) begin
        onehot[PRIO_ORDER[k]] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_code_enc.sv
module exc_code_enc
  import exc_sel_pkg::*;
#(
  parameter int W  = VEC_W,
  parameter int CW = CODE_W
) (
  input  logic [W-1:0]  onehot,
  output logic          any,
  output logic [CW-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot[i]) code = code | CW'(i);
    end
  end
  assign any = |onehot;
endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
  import exc_sel_pkg::*;
#(
  parameter int W       = VEC_W,
  parameter int CW      = CODE_W,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic          fe_only_i,
  input  logic [W-1:0]  pend_i,
  output logic          any_o,
  output logic [CW-1:0] cause_o,
  output logic [W-1:0]  onehot_o
);
  logic [W-1:0]  elig;
  logic [W-1:0]  pick;
  logic          any_c;
  logic [CW-1:0] code_c;

  exc_src_mask #(.W(W)) u_mask (
    .valid(valid_i), .fe_only(fe_only_i), .pend(pend_i), .elig(elig)
  );

  exc_prio_pick #(.W(W)) u_pick (
    .elig(elig), .onehot(pick)
  );

  exc_code_enc #(.W(W), .CW(CW)) u_enc (
    .onehot(pick), .any(any_c), .code(code_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        any_o    <= 1'b0;
        cause_o  <= '0;
        onehot_o <= '0;
      end else begin
        any_o    <= any_c;
        cause_o  <= code_c;
        onehot_o <= pick;
      end
    end
  end else begin : g_comb
    assign any_o    = any_c;
    assign cause_o  = code_c;
    assign onehot_o = pick;
  end
endmodule

// File: rtl/exc_cause_sel_chk.sv
module exc_cause_sel_chk
  import exc_sel_pkg::*;
#(
  parameter int W       = VEC_W,
  parameter int CW      = CODE_W,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          valid_i,
  input logic          fe_only_i,
  input logic [W-1:0]  pend_i,
  input logic          any_o,
  input logic [CW-1:0] cause_o,
  input logic [W-1:0]  onehot_o
);
  localparam logic [W-1:0] FE_M = FE_MASK[W-1:0];

  // R6
  onehot_at_most_one_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(onehot_o));

  // R1
  cause_marks_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    any_o |-> onehot_o[cause_o]);

  // R3
  idle_all_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !any_o |-> (cause_o == '0 && onehot_o == '0));

  // R5
  never_select_chk: assert property (@(posedge clk) disable iff (rst)
    onehot_o[14] == 1'b0 && onehot_o[19:16] == 4'd0);

  if (REG_OUT) begin : g_seq
    // R7
    reset_clears_chk: assert property (@(posedge clk)
      rst |=> (!any_o && cause_o == '0 && onehot_o == '0));

    // R8
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> !any_o);

    // R4
    fe_masked_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_i && fe_only_i) |=> ((onehot_o & ~FE_M) == '0));

    // R1
    pending_seen_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_i && !fe_only_i && (pend_i & ~24'h0F_4000) != '0) |=> any_o);
  end else begin : g_cmb
    // R8
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_i |-> !any_o);

    // R4
    fe_masked_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_i && fe_only_i) |-> ((onehot_o & ~FE_M) == '0));
  end
endmodule

bind exc_cause_sel exc_cause_sel_chk #(.W(W), .CW(CW), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .fe_only_i(fe_only_i),
  .pend_i(pend_i), .any_o(any_o), .cause_o(cause_o), .onehot_o(onehot_o)
);

// File: tb/sim_exc_cause_sel.sv
`timescale 1ns/1ps
module sim_exc_cause_sel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic        fe_only_i = 1'b0;
  logic [23:0] pend_i = '0;
  logic        any_o;
  logic [4:0]  cause_o;
  logic [23:0] onehot_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  exc_cause_sel u0 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .fe_only_i(fe_only_i),
    .pend_i(pend_i), .any_o(any_o), .cause_o(cause_o), .onehot_o(onehot_o)
  );

  // Ranking taken from R2, front-end set from R4
  int rank_tab [19] = '{3, 12, 20, 1, 2, 22, 0, 11, 9, 10, 8, 6, 4, 15, 13, 23, 21, 7, 5};

  function automatic int model_cause(logic v, logic fe, logic [23:0] p);
    logic [23:0] e;
    e = v ? (fe ? (p & ((24'd1 << 0) | (24'd1 << 1) | (24'd1 << 2) |
                        (24'd1 << 12) | (24'd1 << 20) | (24'd1 << 22))) : p) : 24'd0;
    for (int k = 0; k < 19; k++) if (e[rank_tab[k]]) return rank_tab[k];
    return -1;
  endfunction

  task automatic report(input string req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    if (req.len() == 0) $finish;
  endtask

  task automatic check(input string req, input logic ea, input int ec, input logic [23:0] eo);
    n_cmp++;
    if (any_o !== ea || cause_o !== 5'(ec) || onehot_o !== eo) begin
      n_bad++;
      $display("FAIL %s: got any=%0b cause=%0d onehot=%h, want any=%0b cause=%0d onehot=%h",
               req, any_o, cause_o, onehot_o, ea, ec, eo);
    end
  endtask

  // Drive at a falling edge, sample at the falling edge after the next rising edge.
  task automatic apply(input string req, input logic v, input logic fe, input logic [23:0] p);
    int c;
    @(negedge clk);
    valid_i = v; fe_only_i = fe; pend_i = p;
    c = model_cause(v, fe, p);
    @(negedge clk);
    if (c < 0) check(req, 1'b0, 0, 24'd0);
    else       check(req, 1'b1, c, 24'd1 << c);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got cycle=%0d, want < 100000", cyc);
      report("");
    end
  end

  initial begin
    void'($urandom(32'd12345));
    valid_i = 1'b1; pend_i = 24'hFF_FFFF;
    repeat (3) @(negedge clk);
    check("R7 reset clears", 1'b0, 0, 24'd0);
    rst = 1'b0;

    apply("R2 all set -> breakpoint", 1, 0, 24'hFF_FFFF);
    apply("R4 fe all set -> 12", 1, 1, 24'hFF_FFFF);
    apply("R8 valid low ignored", 0, 0, 24'hFF_FFFF);
    apply("R5 only excluded bits", 1, 0, 24'h0F_4000);
    apply("R3 empty vector", 1, 0, 24'd0);
    apply("R2 misaligned over ecall M", 1, 0, (24'd1 << 11) | 24'd1);
    apply("R2 store over load misaligned", 1, 0, (24'd1 << 6) | (24'd1 << 4));
    apply("R2 store over load access", 1, 0, (24'd1 << 7) | (24'd1 << 5));
    apply("R2 lowest rank alone", 1, 0, 24'd1 << 5);
    apply("R2 ecall S over VS", 1, 0, (24'd1 << 9) | (24'd1 << 10) | (24'd1 << 8));
    apply("R4 fe drops load fault", 1, 1, 24'd1 << 5);
    apply("R4 fe virtual over misaligned", 1, 1, (24'd1 << 22) | 24'd1 | (24'd1 << 3));
    apply("R5 excluded plus ecall U", 1, 0, 24'h0F_4000 | (24'd1 << 8));

    // R7: mid-run reset clears a pending result
    @(negedge clk);
    valid_i = 1; fe_only_i = 0; pend_i = 24'd1 << 2; rst = 1'b1;
    @(negedge clk);
    check("R7 sync reset mid-run", 1'b0, 0, 24'd0);
    rst = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      logic [23:0] p;
      case ($urandom % 3)
        0: p = 24'($urandom & $urandom & $urandom);
        1: p = 24'($urandom);
        default: p = 24'd1 << ($urandom % 24);
      endcase
      apply("R1/R2/R6 random", ($urandom % 8) != 0, ($urandom % 3) == 0, p);
    end
    report("");
  end
endmodule